// File: doc/BRIEF.md
# Event Counter Group

A bank of event counters set up over a simple memory-mapped register bus. Each counter picks one event from a vector of event pulses that some upstream filter has already qualified. The counter adds one in each cycle where that event pulses, provided the counter is enabled and the group-wide run bit is on. Software never writes the counter-enable, interrupt-enable or overflow bitmaps directly. Each one has a pair of registers: a write-one-to-set address and a write-one-to-clear address. Either address reads back the current state, so a field can change without a read-modify-write.

When a counter rolls from all ones to zero it raises its overflow flag. A single level interrupt is asserted while any flagged counter also has its interrupt enable set, gated by a group interrupt enable. Software can preload a counter, for example with half of full scale, so that an interrupt arrives after a chosen number of events. Selecting event type 0xFFFF stops a counter at once, even while the group is running. This gives a stop that does not depend on the run bit. A read-only word reports the counter count and width. Two words report which event numbers this instance supports.

Top module: `evt_cnt_group`

## Requirements
- R1: After reset every counter, event type, match word, enable bitmap and overflow flag is zero, both control bits are off, and irq_o is low.
- R2: The word at 0xE00 reads counter count minus one in bits 5:0 and counter width minus one in bits 13:8. All other bits read zero, including bit 20 (relocated counters), bit 21 (message interrupts) and bit 23 (global filter).
- R3: In a cycle where counter i is enabled, the run bit (bit 0 at 0xE04) is set and event pulse number T pulses, counter i adds exactly one. T is the value in bits 15:0 of the type word at 0x400+4i.
- R4: A counter holds its value while its enable bit is clear or the run bit is clear, whatever the event pulses do.
- R5: A counter whose type is 0xFFFF, or any number at or above the event vector width, never counts, even with the run bit set.
- R6: For counter enables (set 0xC00, clear 0xC20) and interrupt enables (set 0xC40, clear 0xC60), writing 1 in bit i sets or clears bit i and leaves 0 bits unchanged. Either address reads the current bitmap, and bits at or above the counter count read zero.
- R7: A counter that steps from all ones to zero sets its overflow bit, and the bit reads as set at 0xCC0 and 0xC80.
- R8: A bus write to counter i (base 0x000, stride 4 bytes for widths up to 32 and 8 bytes otherwise) loads the written value. A write in the same cycle as an increment takes priority over the increment.
- R9: Writing 1s to 0xCC0 sets overflow bits and writing 1s to 0xC80 clears them. A wrap in the same cycle as a clear of the same bit leaves that bit set.
- R10: irq_o is high exactly when bit 0 at 0xE50 is set and some counter has both its overflow bit and its interrupt enable bit set.
- R11: The words at 0xE20 and 0xE28 return the supported-event bitmap for events 0-63 and 64-127. The match word at 0xA00+4i stores and returns 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | Access is a write |
| addr_i | input | 12 | Byte address within the group |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, combinational from addr_i |
| event_i | input | NUM_EV | Event pulses, one per event number |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume at most one bus access per cycle. They also assume a counter changes only by its own write strobe or by a single-step increment, so any other jump is treated as an error. The stimulus keeps every write and every read of a counter in a cycle of its own. It drives event pulses only between register updates, except in the directed cases that deliberately collide a counter load or an overflow clear with a pulse. The random phases draw event vectors, enable masks and type selections, including the halt code, from a fixed seed. A bench model accumulates the expected count for each counter from those draws.

// File: rtl/ecg_pkg.sv
package ecg_pkg;
  localparam logic [11:0] OFF_CNT     = 12'h000;
  localparam logic [11:0] OFF_EVT     = 12'h400;
  localparam logic [11:0] OFF_SMR     = 12'hA00;
  localparam logic [11:0] OFF_CEN_SET = 12'hC00;
  localparam logic [11:0] OFF_CEN_CLR = 12'hC20;
  localparam logic [11:0] OFF_IEN_SET = 12'hC40;
  localparam logic [11:0] OFF_IEN_CLR = 12'hC60;
  localparam logic [11:0] OFF_OVF_CLR = 12'hC80;
  localparam logic [11:0] OFF_OVF_SET = 12'hCC0;
  localparam logic [11:0] OFF_CFG     = 12'hE00;
  localparam logic [11:0] OFF_CTRL    = 12'hE04;
  localparam logic [11:0] OFF_EMAP_LO = 12'hE20;
  localparam logic [11:0] OFF_EMAP_HI = 12'hE28;
  localparam logic [11:0] OFF_IRQCTL  = 12'hE50;
  localparam logic [15:0] EVT_HALT    = 16'hFFFF;

  typedef struct packed {
    logic cen_set;
    logic cen_clr;
    logic ien_set;
    logic ien_clr;
    logic ovf_set;
    logic ovf_clr;
    logic cfg;
    logic ctrl;
    logic emap_lo;
    logic emap_hi;
    logic irqctl;
  } ecg_hit_t;
endpackage

// File: rtl/ecg_decode.sv
module ecg_decode
  import ecg_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input  logic [11:0]        addr_i,
  output logic [NUM_CNT-1:0] cnt_hit_o,
  output logic [NUM_CNT-1:0] evt_hit_o,
  output logic [NUM_CNT-1:0] smr_hit_o,
  output ecg_hit_t           hit_o
);
  localparam int STRIDE = (CNT_W > 32) ? 8 : 4;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_hit
    assign cnt_hit_o[i] = (addr_i == OFF_CNT + 12'(i * STRIDE));
    assign evt_hit_o[i] = (addr_i == OFF_EVT + 12'(i * 4));
    assign smr_hit_o[i] = (addr_i == OFF_SMR + 12'(i * 4));
  end

  always_comb begin
    hit_o.cen_set = (addr_i == OFF_CEN_SET);
    hit_o.cen_clr = (addr_i == OFF_CEN_CLR);
    hit_o.ien_set = (addr_i == OFF_IEN_SET);
    hit_o.ien_clr = (addr_i == OFF_IEN_CLR);
    hit_o.ovf_set = (addr_i == OFF_OVF_SET);
    hit_o.ovf_clr = (addr_i == OFF_OVF_CLR);
    hit_o.cfg     = (addr_i == OFF_CFG);
    hit_o.ctrl    = (addr_i == OFF_CTRL);
    hit_o.emap_lo = (addr_i == OFF_EMAP_LO);
    hit_o.emap_hi = (addr_i == OFF_EMAP_HI);
    hit_o.irqctl  = (addr_i == OFF_IRQCTL);
  end
endmodule

// File: rtl/ecg_bitreg.sv
module ecg_bitreg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  // hardware set wins over a software clear in the same cycle
  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = q_d & ~mask_i;
    if (set_i) q_d = q_d | mask_i;
    q_d = q_d | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/ecg_counter.sv
module ecg_counter
  import ecg_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_EV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [15:0]       evt_i,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  logic sel;
  logic inc;

  always_comb begin
    sel = 1'b0;
    for (int k = 0; k < NUM_EV; k++)
      if (evt_i == 16'(k)) sel = ev_i[k];
  end

  assign inc    = run_i && (evt_i != EVT_HALT) && sel;
  assign wrap_o = inc && !we_i && (&cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_o <= '0;
    else if (we_i) cnt_o <= wdata_i;
    else if (inc)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/evt_cnt_group.sv
module evt_cnt_group
  import ecg_pkg::*;
#(
  parameter int           NUM_CNT = 4,
  parameter int           CNT_W   = 32,
  parameter int           NUM_EV  = 8,
  parameter logic [127:0] EV_MAP  = 128'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  input  logic [NUM_EV-1:0] event_i,
  output logic              irq_o
);
  localparam logic [5:0] NCNT_M1 = 6'(NUM_CNT - 1);
  localparam logic [5:0] WID_M1  = 6'(CNT_W - 1);

  logic [NUM_CNT-1:0] cnt_hit, evt_hit, smr_hit;
  ecg_hit_t           hit;
  logic               wr;
  logic [NUM_CNT-1:0] cnt_we;
  logic [NUM_CNT-1:0] run;
  logic [NUM_CNT-1:0] halt;
  logic [NUM_CNT-1:0] wrap;
  logic [NUM_CNT-1:0] cen_q, ien_q, ovf_q;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CNT-1:0][15:0]      evt_q;
  logic [NUM_CNT-1:0][31:0]      smr_q;
  logic               glb_en_q, irq_en_q;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr = req_i && we_i;

  ecg_decode #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_dec (
    .addr_i    (addr_i),
    .cnt_hit_o (cnt_hit),
    .evt_hit_o (evt_hit),
    .smr_hit_o (smr_hit),
    .hit_o     (hit)
  );

  ecg_bitreg #(.W(NUM_CNT)) u_cen (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (wr && hit.cen_set), .clr_i (wr && hit.cen_clr),
    .mask_i (wdata_i[NUM_CNT-1:0]), .hw_set_i ('0), .q_o (cen_q)
  );

  ecg_bitreg #(.W(NUM_CNT)) u_ien (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (wr && hit.ien_set), .clr_i (wr && hit.ien_clr),
    .mask_i (wdata_i[NUM_CNT-1:0]), .hw_set_i ('0), .q_o (ien_q)
  );

  ecg_bitreg #(.W(NUM_CNT)) u_ovf (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (wr && hit.ovf_set), .clr_i (wr && hit.ovf_clr),
    .mask_i (wdata_i[NUM_CNT-1:0]), .hw_set_i (wrap), .q_o (ovf_q)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign cnt_we[i] = wr && cnt_hit[i];
    assign run[i]    = glb_en_q && cen_q[i];
    assign halt[i]   = (evt_q[i] == EVT_HALT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        evt_q[i] <= '0;
        smr_q[i] <= '0;
      end else begin
        if (wr && evt_hit[i]) evt_q[i] <= wdata_i[15:0];
        if (wr && smr_hit[i]) smr_q[i] <= wdata_i[31:0];
      end
    end

    ecg_counter #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) u_counter (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run[i]),
      .evt_i   (evt_q[i]),
      .ev_i    (event_i),
      .we_i    (cnt_we[i]),
      .wdata_i (wdata_i[CNT_W-1:0]),
      .cnt_o   (cnt_all[i]),
      .wrap_o  (wrap[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (wr && hit.ctrl)   glb_en_q <= wdata_i[0];
      if (wr && hit.irqctl) irq_en_q <= wdata_i[0];
    end
  end

  assign irq_o = irq_en_q && |(ovf_q & ien_q);

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (cnt_hit[i]) rdata_o[CNT_W-1:0] = cnt_all[i];
      if (evt_hit[i]) rdata_o[15:0]      = evt_q[i];
      if (smr_hit[i]) rdata_o[31:0]      = smr_q[i];
    end
    if (hit.cen_set || hit.cen_clr) rdata_o[NUM_CNT-1:0] = cen_q;
    if (hit.ien_set || hit.ien_clr) rdata_o[NUM_CNT-1:0] = ien_q;
    if (hit.ovf_set || hit.ovf_clr) rdata_o[NUM_CNT-1:0] = ovf_q;
    if (hit.cfg) begin
      rdata_o[5:0]  = NCNT_M1;
      rdata_o[13:8] = WID_M1;
    end
    if (hit.ctrl)    rdata_o[0] = glb_en_q;
    if (hit.irqctl)  rdata_o[0] = irq_en_q;
    if (hit.emap_lo) rdata_o    = EV_MAP[63:0];
    if (hit.emap_hi) rdata_o    = EV_MAP[127:64];
  end
endmodule

// File: rtl/ecg_checker.sv
module ecg_checker #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_CNT-1:0]            cnt_we_i,
  input logic [CNT_W-1:0]              wdata_i,
  input logic [NUM_CNT-1:0]            run_i,
  input logic [NUM_CNT-1:0]            halt_i,
  input logic [NUM_CNT-1:0]            ovf_i,
  input logic                          irq_en_i,
  input logic                          irq_i
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_we_i[i] |=> (cnt_i[i] == $past(cnt_i[i]) ||
                        cnt_i[i] == CNT_W'($past(cnt_i[i]) + 1'b1))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i[i] && !cnt_we_i[i]) |=> $stable(cnt_i[i])); // R4
    AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_i[i] && !cnt_we_i[i]) |=> $stable(cnt_i[i])); // R5
    AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cnt_we_i[i] && (&cnt_i[i])) |=> (cnt_i[i] != '0 || ovf_i[i])); // R7
    AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_we_i[i] |=> cnt_i[i] == $past(wdata_i)); // R8
  end

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_i); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (ovf_i != '0)); // R10
endmodule

bind evt_cnt_group ecg_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_i    (cnt_all),
  .cnt_we_i (cnt_we),
  .wdata_i  (wdata_i[CNT_W-1:0]),
  .run_i    (run),
  .halt_i   (halt),
  .ovf_i    (ovf_q),
  .irq_en_i (irq_en_q),
  .irq_i    (irq_o)
);

// File: tb/evt_cnt_group_bench.sv
module evt_cnt_group_bench;
  localparam int NC = 4;
  localparam int NE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [NE-1:0] ev = '0;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [NE-1:0] ev_w = '0;
  logic [31:0] exp_cnt [NC];
  logic [15:0] exp_evt [NC];
  logic [NC-1:0] exp_cen;
  logic glb;

  always #5 clk = ~clk;

  evt_cnt_group u_evt_cnt_group (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(ev), .irq_o(irq)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; ev = ev_w;
    @(posedge clk); #1;
    req = 0; we = 0; ev = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; #1;
    d = rdata;
    req = 0;
  endtask

  task automatic pulse(logic [NE-1:0] v);
    @(negedge clk);
    ev = v;
    @(posedge clk); #1;
    ev = '0;
  endtask

  function automatic bit counts(int i, logic [NE-1:0] v);
    if (!glb || !exp_cen[i]) return 0;
    if (exp_evt[i] >= 16'(NE)) return 0;
    return v[exp_evt[i]];
  endfunction

  task automatic run_events(int cycles);
    for (int c = 0; c < cycles; c++) begin
      logic [NE-1:0] v;
      v = NE'($urandom);
      for (int i = 0; i < NC; i++) if (counts(i, v)) exp_cnt[i]++;
      pulse(v);
    end
  endtask

  task automatic check_all(string tag);
    logic [63:0] d;
    for (int i = 0; i < NC; i++) begin
      rd(12'(4 * i), d);
      check(tag, d, 64'(exp_cnt[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd7321));
    for (int i = 0; i < NC; i++) begin exp_cnt[i] = '0; exp_evt[i] = '0; end
    exp_cen = '0; glb = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1 reset state
    #1 check("R1 irq", 64'(irq), 0);
    check_all("R1 counters");
    rd(12'hC00, d); check("R1 cen", d, 0);
    rd(12'hCC0, d); check("R1 ovf", d, 0);
    rd(12'h404, d); check("R1 evt", d, 0);
    rd(12'hE04, d); check("R1 ctrl", d, 0);
    // R2 configuration
    rd(12'hE00, d); check("R2 cfg", d, 64'h1F03);
    // R11 event map and match word
    rd(12'hE20, d); check("R11 map lo", d, 64'hFF);
    rd(12'hE28, d); check("R11 map hi", d, 0);
    wr(12'hA08, 64'hFFFF_FFFF_DEAD_0042);
    rd(12'hA08, d); check("R11 smr", d, 64'hDEAD_0042);
    rd(12'hA04, d); check("R11 smr other", d, 0);

    // R6 set/clear pairs
    wr(12'hC00, 64'h5); rd(12'hC20, d); check("R6 cen set", d, 64'h5);
    wr(12'hC00, 64'h2); rd(12'hC00, d); check("R6 cen set2", d, 64'h7);
    wr(12'hC20, 64'h4); rd(12'hC20, d); check("R6 cen clr", d, 64'h3);
    wr(12'hC00, 64'hF0); rd(12'hC00, d); check("R6 cen hi bits", d, 64'h3);
    wr(12'hC40, 64'hA); rd(12'hC60, d); check("R6 ien set", d, 64'hA);
    wr(12'hC60, 64'hA); rd(12'hC40, d); check("R6 ien clr", d, 0);

    // R4 run bit off: no counting
    wr(12'h400, 0); wr(12'h404, 1); wr(12'h408, 2); wr(12'h40C, 64'hFFFF);
    exp_evt[0] = 0; exp_evt[1] = 1; exp_evt[2] = 2; exp_evt[3] = 16'hFFFF;
    wr(12'hC00, 64'hF); exp_cen = 4'hF;
    for (int c = 0; c < 6; c++) pulse(8'hFF);
    check_all("R4 run off");

    // R3 single step, R5 halt with run on
    wr(12'hE04, 1); glb = 1;
    pulse(8'h01); exp_cnt[0]++;
    check_all("R3 single step");
    run_events(60);
    check_all("R3 R5 random");
    wr(12'h40C, 9); exp_evt[3] = 9;
    run_events(30);
    check_all("R5 out of range type");

    // R3 R4 R5 random rounds
    for (int r = 0; r < 4; r++) begin
      logic [NC-1:0] m;
      m = NC'($urandom);
      wr(12'hC00, 64'(m)); wr(12'hC20, 64'(~m)); exp_cen = m;
      for (int i = 0; i < NC; i++) begin
        int s;
        s = $urandom % 9;
        exp_evt[i] = (s == 8) ? 16'hFFFF : 16'(s);
        wr(12'(12'h400 + 4 * i), 64'(exp_evt[i]));
      end
      run_events(50);
      check_all("R3 R4 R5 round");
    end

    // R8 write wins over increment
    wr(12'h400, 0); wr(12'hC00, 64'hF); exp_evt[0] = 0; exp_cen = 4'hF;
    ev_w = 8'h01; wr(12'h000, 64'd100); ev_w = '0;
    rd(12'h000, d); check("R8 write priority", d, 64'd100);

    // R7 wrap
    wr(12'hC80, 64'hF);
    wr(12'h404, 1); exp_evt[1] = 1;
    wr(12'h004, 64'hFFFF_FFFE);
    pulse(8'h02);
    rd(12'hCC0, d); check("R7 no ovf before wrap", d, 0);
    rd(12'h004, d); check("R7 all ones", d, 64'hFFFF_FFFF);
    pulse(8'h02);
    rd(12'h004, d); check("R7 wrapped", d, 0);
    rd(12'hC80, d); check("R7 ovf set", d, 64'h2);

    // R10 interrupt gating
    #1 check("R10 no ien", 64'(irq), 0);
    wr(12'hC40, 64'h2);
    #1 check("R10 ctl off", 64'(irq), 0);
    wr(12'hE50, 1);
    #1 check("R10 irq on", 64'(irq), 1);
    // R9 clear drops the interrupt
    wr(12'hC80, 64'h2);
    rd(12'hCC0, d); check("R9 ovf clr", d, 0);
    #1 check("R10 irq off", 64'(irq), 0);

    // R9 software set
    wr(12'hCC0, 64'h8);
    rd(12'hC80, d); check("R9 ovf set", d, 64'h8);
    #1 check("R10 masked", 64'(irq), 0);
    wr(12'hC40, 64'h8);
    #1 check("R10 set path", 64'(irq), 1);
    wr(12'hC80, 64'h8);

    // R9 wrap beats clear in the same cycle
    wr(12'h000, 64'hFFFF_FFFF);
    ev_w = 8'h01; wr(12'hC80, 64'h1); ev_w = '0;
    rd(12'hCC0, d); check("R9 hw set wins", d, 64'h1);
    rd(12'h000, d); check("R9 counter wrapped", d, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule